// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a single-issue 32-bit RISC core fetches next. Every instruction is one 32-bit word. The core gives the block the current program counter, the fetched instruction word and the two register operands read for the instruction's source fields. In the same cycle, with no internal state, the block returns four things:

- the next program counter;
- a flag saying whether control left the sequential path;
- a request to write the return address into the link register;
- the instruction's format class.

Two equality-test branches use a displacement taken relative to the program counter and counted in words. Two absolute jumps, one of them a call, splice a 26-bit word target under the top bits of the incremented program counter. A register jump loads the next address straight from the first operand. Every other instruction falls through to the next word.

Top module: `npc_unit`

## Requirements
- R1: `fmt_o` reports 2'd0 (register format) when the opcode in bits [31:26] is zero. It reports 2'd2 (jump format) for opcodes 6'h02 and 6'h03, and 2'd1 (immediate format) for every other opcode.
- R2: An instruction that is neither a branch nor a jump gives `next_pc_o` = `pc_i` + 4 and `taken_o` = 0. This covers register-format words whose function code in bits [5:0] is not 6'h08.
- R3: Opcode 6'h04 is taken only when `rs_val_i` equals `rt_val_i`. When taken, `next_pc_o` = `pc_i` + 4 + 4 × imm and `taken_o` = 1, where imm is bits [15:0]. When not taken, `next_pc_o` is `pc_i` + 4.
- R4: Opcode 6'h05 is taken only when `rs_val_i` differs from `rt_val_i`, using the same target rule as R3. When not taken, `next_pc_o` is `pc_i` + 4 with `taken_o` = 0.
- R5: The 16-bit displacement is sign-extended, so imm 16'hFFFE moves back 8 bytes from `pc_i` + 4 and imm 16'h8000 moves back 131072 bytes.
- R6: Opcode 6'h02 sets `taken_o` = 1 and `next_pc_o` = {upper 4 bits, bits [25:0], 2'b00}.
- R7: Opcode 6'h03 jumps to the same target as R6. It also raises `link_we_o` with `link_idx_o` = 31.
- R8: A register-format word (opcode 0) with function code 6'h08 sets `next_pc_o` = `rs_val_i` and `taken_o` = 1.
- R9: `link_val_o` always equals `pc_i` + 4. `link_we_o` is 0 for every opcode other than 6'h03.
- R10: The upper 4 bits of a jump target come from `pc_i` + 4, not from `pc_i`. With `pc_i` = 32'h0FFFFFFC they are 4'h1.
- R11: The incremented address wraps modulo 2^32, so `pc_i` = 32'hFFFFFFFC falls through to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Write the return address to the link register |
| link_idx_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Return address, `pc_i` + 4 |
| fmt_o | output | 2 | Format class: 0 register, 1 immediate, 2 jump |

## Verification
Each branch opcode is driven twice, once with equal operands and once with unequal ones, so that inverting a condition or swapping the two opcodes is exposed. Positive, negative and most-negative displacements separate real sign extension from zero extension and from a missing word scale. Two jumps are driven:
- one whose program counter is at a 256 MB boundary, which shows whether the spliced upper bits come from the incremented address;
- one with an all-ones target, which checks that no target bit is dropped.

Register-format words with and without the return function code separate the register jump from ordinary arithmetic. A run of random words mixing all opcodes is then compared against a model written inside the bench.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      FMT_REG  = 2'd0,
      FMT_IMM  = 2'd1,
      FMT_JUMP = 2'd2
   } fmt_e;

   typedef enum logic [2:0] {
      CF_SEQ = 3'd0,
      CF_BEQ = 3'd1,
      CF_BNE = 3'd2,
      CF_JMP = 3'd3,
      CF_JAL = 3'd4,
      CF_JR  = 3'd5
   } cflow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int OP_W   = 6,
   parameter int FN_W   = 6,
   parameter int IMM_W  = 16,
   parameter logic [OP_W-1:0] OP_BEQ = 6'h04,
   parameter logic [OP_W-1:0] OP_BNE = 6'h05,
   parameter logic [OP_W-1:0] OP_JMP = 6'h02,
   parameter logic [OP_W-1:0] OP_JAL = 6'h03,
   parameter logic [FN_W-1:0] FN_JR  = 6'h08,
   localparam int TGT_W = XLEN - OP_W
) (
   input  logic [XLEN-1:0]  instr,
   output logic [IMM_W-1:0] imm,
   output logic [TGT_W-1:0] tgt,
   output fmt_e             fmt,
   output cflow_e           cflow
);
   logic [OP_W-1:0] opcode;
   logic [FN_W-1:0] funct;

   assign opcode = instr[XLEN-1 -: OP_W];
   assign tgt    = instr[TGT_W-1:0];
   assign imm    = tgt[IMM_W-1:0];
   assign funct  = imm[FN_W-1:0];

   always_comb begin
      if (opcode == '0)
         fmt = FMT_REG;
      else if (opcode == OP_JMP || opcode == OP_JAL)
         fmt = FMT_JUMP;
      else
         fmt = FMT_IMM;
   end

   always_comb begin
      cflow = CF_SEQ;
      if (opcode == '0) begin
         if (funct == FN_JR) cflow = CF_JR;
      end else if (opcode == OP_BEQ) cflow = CF_BEQ;
      else if (opcode == OP_BNE)     cflow = CF_BNE;
      else if (opcode == OP_JMP)     cflow = CF_JMP;
      else if (opcode == OP_JAL)     cflow = CF_JAL;
   end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  cflow_e          cflow,
   output logic            take
);
   logic same;

   assign same = (a == b);

   always_comb begin
      unique case (cflow)
         CF_BEQ:                take = same;
         CF_BNE:                take = !same;
         CF_JMP, CF_JAL, CF_JR: take = 1'b1;
         default:               take = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN             = 32,
   parameter int IMM_W            = 16,
   parameter int TGT_W            = 26,
   parameter bit SPLICE_FROM_NEXT = 1'b1,
   localparam int ALIGN_W = $clog2(XLEN / 8),
   localparam int HI_W    = XLEN - TGT_W - ALIGN_W
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  jr_addr,
   input  logic [IMM_W-1:0] imm,
   input  logic [TGT_W-1:0] tgt,
   input  cflow_e           cflow,
   input  logic             take,
   output logic [XLEN-1:0]  pc_inc,
   output logic [XLEN-1:0]  next_pc
);
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] j_tgt;
   logic [HI_W-1:0] hi_bits;

   assign pc_inc = pc + XLEN'(XLEN / 8);
   assign disp   = {{(XLEN - IMM_W - ALIGN_W){imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
   assign br_tgt = pc_inc + disp;

   generate
      if (SPLICE_FROM_NEXT) begin : g_hi_next
         assign hi_bits = pc_inc[XLEN-1 -: HI_W];
      end else begin : g_hi_cur
         assign hi_bits = pc[XLEN-1 -: HI_W];
      end
   endgenerate

   assign j_tgt = {hi_bits, tgt, {ALIGN_W{1'b0}}};

   always_comb begin
      next_pc = pc_inc;
      if (take) begin
         unique case (cflow)
            CF_BEQ, CF_BNE: next_pc = br_tgt;
            CF_JMP, CF_JAL: next_pc = j_tgt;
            CF_JR:          next_pc = jr_addr;
            default:        next_pc = pc_inc;
         endcase
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN             = 32,
   parameter int OP_W             = 6,
   parameter int REG_W            = 5,
   parameter int SH_W             = 5,
   parameter int FN_W             = 6,
   parameter int LINK_REG         = 31,
   parameter bit SPLICE_FROM_NEXT = 1'b1,
   parameter logic [OP_W-1:0] OP_BEQ = 6'h04,
   parameter logic [OP_W-1:0] OP_BNE = 6'h05,
   parameter logic [OP_W-1:0] OP_JMP = 6'h02,
   parameter logic [OP_W-1:0] OP_JAL = 6'h03,
   parameter logic [FN_W-1:0] FN_JR  = 6'h08
) (
   input  logic [31:0] pc_i,
   input  logic [31:0] instr_i,
   input  logic [31:0] rs_val_i,
   input  logic [31:0] rt_val_i,
   output logic [31:0] next_pc_o,
   output logic        taken_o,
   output logic        link_we_o,
   output logic [4:0]  link_idx_o,
   output logic [31:0] link_val_o,
   output logic [1:0]  fmt_o
);
   localparam int IMM_W = XLEN - OP_W - 2 * REG_W;
   localparam int TGT_W = XLEN - OP_W;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("npc_unit: port widths assume XLEN of 32");
      end
      if (OP_W + 3 * REG_W + SH_W + FN_W != XLEN) begin : g_bad_fields
         $error("npc_unit: instruction fields do not fill the word");
      end
      if (REG_W != 5 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("npc_unit: link register index out of range");
      end
   endgenerate

   logic [IMM_W-1:0] imm;
   logic [TGT_W-1:0] tgt;
   fmt_e             fmt;
   cflow_e           cflow;
   logic             take;
   logic [XLEN-1:0]  pc_inc;

   npc_decode #(
      .XLEN(XLEN), .OP_W(OP_W), .FN_W(FN_W), .IMM_W(IMM_W),
      .OP_BEQ(OP_BEQ), .OP_BNE(OP_BNE), .OP_JMP(OP_JMP),
      .OP_JAL(OP_JAL), .FN_JR(FN_JR)
   ) u_decode (
      .instr(instr_i), .imm(imm), .tgt(tgt), .fmt(fmt), .cflow(cflow)
   );

   npc_cond #(.XLEN(XLEN)) u_cond (
      .a(rs_val_i), .b(rt_val_i), .cflow(cflow), .take(take)
   );

   npc_target #(
      .XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W),
      .SPLICE_FROM_NEXT(SPLICE_FROM_NEXT)
   ) u_target (
      .pc(pc_i), .jr_addr(rs_val_i), .imm(imm), .tgt(tgt),
      .cflow(cflow), .take(take), .pc_inc(pc_inc), .next_pc(next_pc_o)
   );

   assign taken_o    = take;
   assign link_we_o  = (cflow == CF_JAL);
   assign link_idx_o = REG_W'(LINK_REG);
   assign link_val_o = pc_inc;
   assign fmt_o      = fmt;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int LINK_REG = 31,
   parameter logic [5:0] OP_JMP = 6'h02,
   parameter logic [5:0] OP_JAL = 6'h03,
   parameter logic [5:0] FN_JR  = 6'h08
) (
   input logic [31:0] pc_i,
   input logic [31:0] instr_i,
   input logic [31:0] rs_val_i,
   input logic [31:0] next_pc_o,
   input logic        taken_o,
   input logic        link_we_o,
   input logic [4:0]  link_idx_o,
   input logic [31:0] link_val_o,
   input logic [1:0]  fmt_o
);
   logic [5:0] op;
   logic [5:0] fn;
   logic       is_jump;

   assign op      = instr_i[31:26];
   assign fn      = instr_i[5:0];
   assign is_jump = (op == OP_JMP) || (op == OP_JAL);

   always_comb begin
      AST_REG_FORMAT: assert (op != 6'h00 || fmt_o == 2'd0) else $error("format"); // R1
      AST_SEQ_FALLTHROUGH: assert (taken_o || next_pc_o == pc_i + 32'd4) else $error("seq"); // R2
      AST_JUMP_TARGET: assert (!is_jump || (taken_o && next_pc_o[27:0] == {instr_i[25:0], 2'b00})) else $error("jump"); // R6
      AST_LINK_INDEX: assert (!link_we_o || link_idx_o == 5'(LINK_REG)) else $error("link idx"); // R7
      AST_REG_JUMP: assert (!(op == 6'h00 && fn == FN_JR) || (taken_o && next_pc_o == rs_val_i)) else $error("jr"); // R8
      AST_LINK_ONLY_CALL: assert (!link_we_o || op == OP_JAL) else $error("link we"); // R9
      AST_LINK_VALUE: assert (link_val_o == pc_i + 32'd4) else $error("link val"); // R9
   end
endmodule

bind npc_unit npc_unit_chk #(
   .LINK_REG(LINK_REG), .OP_JMP(OP_JMP), .OP_JAL(OP_JAL), .FN_JR(FN_JR)
) u_npc_chk (
   .pc_i(pc_i), .instr_i(instr_i), .rs_val_i(rs_val_i),
   .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
   .link_idx_o(link_idx_o), .link_val_o(link_val_o), .fmt_o(fmt_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] pc, instr, rs_v, rt_v;
   logic [31:0] next_pc, link_val;
   logic        taken, link_we;
   logic [4:0]  link_idx;
   logic [1:0]  fmt;

   int n_run = 0;
   int n_fail = 0;

   npc_unit i_npc_unit (
      .pc_i(pc), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
      .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
      .link_idx_o(link_idx), .link_val_o(link_val), .fmt_o(fmt)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] ins;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] nxt;
      logic        tk;
      logic        we;
      logic [1:0]  fm;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{32'h00001000, 32'h00000000, 32'd0, 32'd0, 32'h00001004, 1'b0, 1'b0, 2'd0}, // R2 nop
      '{32'h00001000, 32'h10220010, 32'd5, 32'd5, 32'h00001044, 1'b1, 1'b0, 2'd1}, // R3 eq taken
      '{32'h00001000, 32'h10220010, 32'd5, 32'd6, 32'h00001004, 1'b0, 1'b0, 2'd1}, // R3 eq not taken
      '{32'h00001000, 32'h14220010, 32'd5, 32'd6, 32'h00001044, 1'b1, 1'b0, 2'd1}, // R4 ne taken
      '{32'h00001000, 32'h14220010, 32'd5, 32'd5, 32'h00001004, 1'b0, 1'b0, 2'd1}, // R4 ne not taken
      '{32'h00001000, 32'h1022FFFE, 32'd7, 32'd7, 32'h00000FFC, 1'b1, 1'b0, 2'd1}, // R5 backward
      '{32'h00040000, 32'h14228000, 32'd1, 32'd2, 32'h00020004, 1'b1, 1'b0, 2'd1}, // R5 most negative
      '{32'h00400000, 32'h08000400, 32'd0, 32'd0, 32'h00001000, 1'b1, 1'b0, 2'd2}, // R6 jump
      '{32'hA0000000, 32'h0BFFFFFF, 32'd0, 32'd0, 32'hAFFFFFFC, 1'b1, 1'b0, 2'd2}, // R6 all-ones target
      '{32'h00400010, 32'h0C000100, 32'd0, 32'd0, 32'h00000400, 1'b1, 1'b1, 2'd2}, // R7 call
      '{32'h00001000, 32'h03E00008, 32'h00400014, 32'd9, 32'h00400014, 1'b1, 1'b0, 2'd0}, // R8 reg jump
      '{32'h00002000, 32'h00221820, 32'd3, 32'd4, 32'h00002004, 1'b0, 1'b0, 2'd0}, // R2 add
      '{32'h00002000, 32'h8C430004, 32'd3, 32'd3, 32'h00002004, 1'b0, 1'b0, 2'd1}, // R1 load
      '{32'h0FFFFFFC, 32'h08000010, 32'd0, 32'd0, 32'h10000040, 1'b1, 1'b0, 2'd2}, // R10 splice
      '{32'hFFFFFFFC, 32'h00221820, 32'd0, 32'd0, 32'h00000000, 1'b0, 1'b0, 2'd0}  // R11 wrap
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Bench model built from the requirements
   task automatic model(input logic [31:0] p, input logic [31:0] w,
                        input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] nx, output logic tk,
                        output logic we, output logic [1:0] fm);
      logic [31:0] inc;
      logic [5:0]  op;
      inc = p + 32'd4;
      op  = w[31:26];
      nx = inc; tk = 1'b0; we = 1'b0;
      fm = (op == 6'h00) ? 2'd0 : ((op == 6'h02 || op == 6'h03) ? 2'd2 : 2'd1);
      if ((op == 6'h04 && a == b) || (op == 6'h05 && a != b)) begin
         tk = 1'b1;
         nx = inc + {{14{w[15]}}, w[15:0], 2'b00};
      end else if (op == 6'h02 || op == 6'h03) begin
         tk = 1'b1;
         nx = {inc[31:28], w[25:0], 2'b00};
         we = (op == 6'h03);
      end else if (op == 6'h00 && w[5:0] == 6'h08) begin
         tk = 1'b1;
         nx = a;
      end
   endtask

   task automatic apply_and_check(input logic [31:0] p, input logic [31:0] w,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] e_nx, input logic e_tk,
                                  input logic e_we, input logic [1:0] e_fm);
      @(posedge clk);
      pc = p; instr = w; rs_v = a; rt_v = b;
      @(negedge clk);
      check("R2/R3/R4/R5/R6/R8 next pc", next_pc, e_nx);
      check("R2/R3/R4/R6/R8 taken", {31'd0, taken}, {31'd0, e_tk});
      check("R7/R9 link write", {31'd0, link_we}, {31'd0, e_we});
      check("R1 format", {30'd0, fmt}, {30'd0, e_fm});
      check("R9 link value", link_val, p + 32'd4);
      if (e_we) check("R7 link index", {27'd0, link_idx}, 32'd31);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] e_nx;
      logic        e_tk, e_we;
      logic [1:0]  e_fm;
      pc = '0; instr = '0; rs_v = '0; rt_v = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 initial state: all-zero inputs fall through to address 4
      check("R2 initial next pc", next_pc, 32'd4);
      check("R2 initial taken", {31'd0, taken}, 32'd0);

      for (int i = 0; i < NV; i++)
         apply_and_check(VECS[i].pc, VECS[i].ins, VECS[i].rs, VECS[i].rt,
                         VECS[i].nxt, VECS[i].tk, VECS[i].we, VECS[i].fm);

      // R10 same jump from the address before the boundary differs from splicing pc
      apply_and_check(32'h1FFFFFFC, 32'h0C000001, 32'd0, 32'd0,
                      32'h20000004, 1'b1, 1'b1, 2'd2);
      // R8 opcode zero with another function code is sequential
      apply_and_check(32'h00003000, 32'h03E00009, 32'h12345678, 32'd0,
                      32'h00003004, 1'b0, 1'b0, 2'd0);

      // Random words over all opcode classes compared with the model
      for (int k = 0; k < 400; k++) begin
         logic [31:0] w, p, a, b;
         logic [5:0]  ops [7];
         ops = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h23, 6'h08};
         w = $urandom;
         w[31:26] = ops[$urandom % 7];
         if (w[31:26] == 6'h00 && ($urandom % 2) == 0) w[5:0] = 6'h08;
         p = {$urandom, 2'b00} ;
         a = $urandom;
         b = (($urandom % 2) == 0) ? a : $urandom;
         model(p, w, a, b, e_nx, e_tk, e_we, e_fm);
         apply_and_check(p, w, a, b, e_nx, e_tk, e_we, e_fm);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule